// File: doc/BRIEF.md
# Daisy-Chain Serial Frame Sender

This block feeds a chain of motor-driver chips through one shared serial link. The link has a serial clock, a data line toward the chain, an active-low chip-select and a return data line. Each frame carries one slot per driver. The first bit of every slot is a per-driver flag bit, followed by the driver's datagram bits. The serial clock comes from a programmable divider with a clamped lower limit, so its duty cycle stays symmetric.

A frame goes out when the host hands over a payload. When continuous update is enabled, per-motor timers also ask for a frame. Each timer's period is set by its own rate exponent. A periodic frame repeats the last payload that was sent. The return line is collected into a receive word. The multiplexed reference-switch inputs are captured only on serial rising edges while a frame is running. Both the receive word and the captured switches are published together when the frame ends.

The payload input uses a valid/ready handshake backed by one holding register. `tx_ready` is high only while that register is empty. A payload that arrives while a frame is running waits there and leaves as the next frame. While the holding register is full, `tx_ready` stays low and the host must keep `tx_data` and `tx_valid` stable until the register is emptied.

Top module: `dcx_chain_tx`

## Requirements
- R1: During and just after reset: `cs_n`=1, `sclk`=1, `mosi`=0, `busy`=0, `done`=0, `tx_ready`=1 and `ref_sw_stat`=0.
- R2: Until the first `div_load`, the divider setting is 15, so each serial half-phase lasts 16 system clocks.
- R3: Each serial half-phase lasts `max(div,7)+1` system clocks. A loaded divider value below 7 acts exactly like 7.
- R4: `cs_n` is low, and `busy` is high, for exactly `2H*(N*(LEN+1)+2)` system clocks, plus any flag-bit stretch. H is the half-phase length, N is the number of drivers and LEN is the datagram length. This includes one idle-high serial period before the first bit and one after the last bit.
- R5: The flag bit that opens each driver slot lasts one serial period when the effective divider is 7. Above 7 it lasts 1.5 periods, with its high phase doubled.
- R6: `mosi` changes only on falling `sclk` edges. It carries the payload MSB first, with `N*(LEN+1)` rising edges per frame. `sclk` stays high while `cs_n` is high.
- R7: `miso` is sampled on each rising `sclk` edge, MSB first. The resulting word appears on `rx_data` when `done` pulses.
- R8: With `cont_upd`=0, no frame starts without an accepted payload, and the link stays idle.
- R9: With `cont_upd`=1, motor i asks for a frame every `2^(BASE+ramp_div_i)` system clocks, counted from enable. The frame repeats the last payload sent.
- R10: Periodic requests that arrive while a frame runs merge into one pending frame, which starts one cycle after the current frame ends. Clearing `cont_upd` drops a pending periodic request.
- R11: Accepting a payload drops `tx_ready` on the next cycle. A payload accepted during a frame is sent as the next frame, after exactly one cycle with `cs_n` high.
- R12: `ref_sw_stat` changes only when a frame ends. It shows the switch value captured on that frame's last rising edge. Switch changes while the link is idle have no effect.
- R13: `done` is a one-cycle pulse, in the same cycle that `busy` falls and `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Payload offered |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | NUM_DRV*(DGRAM_LEN+1) | Frame payload, first driver slot in the MSBs |
| div_load | input | 1 | Load strobe for the divider setting |
| div_value | input | DIV_W | New divider setting |
| cont_upd | input | 1 | Enable periodic frames |
| ramp_div | input | NUM_DRV*RDIV_W | Per-motor rate exponents, motor 0 in the LSBs |
| sclk | output | 1 | Serial clock, parked high |
| mosi | output | 1 | Serial data toward the chain |
| cs_n | output | 1 | Active-low chip-select |
| miso | input | 1 | Serial data returned by the chain |
| ref_sw_in | input | SW_W | Multiplexed reference-switch inputs |
| busy | output | 1 | Frame in progress |
| done | output | 1 | End-of-frame pulse |
| ref_sw_stat | output | SW_W | Switch states captured during the last frame |
| rx_data | output | NUM_DRV*(DGRAM_LEN+1) | Word returned by the last frame |

## Verification
The frame engine is swept over divider values on both sides of the clamp, including 0, 5, 6, 7, 8, 9, 12, 15 and 20. Each divider value is combined with all-zero, all-one and two alternating payloads. This separates the clamp, the stretched flag bit, the bit order and the receive path. The return line is looped back to `mosi`, so any misplaced sampling edge shows up as a mismatch in `rx_data`. The periodic schedule runs twice. With slow timers, the frame count must match the number of distinct tick times. With timers faster than a frame, frames must run back to back with a one-cycle gap, which shows that requests merge. Further runs cover a payload arriving during a frame, switch changes while idle, and the default divider after reset.

// File: rtl/dcx_pkg.sv
package dcx_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_LEAD,
    ENG_BIT,
    ENG_TRAIL
  } eng_state_e;

endpackage

// File: rtl/dcx_div_cfg.sv
module dcx_div_cfg #(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 15,
  parameter int DIV_MIN = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] value,
  output logic [DIV_W-1:0] div_eff,
  output logic             stretch
);

  logic [DIV_W-1:0] raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= DIV_W'(DIV_RST);
    end else if (load) begin
      raw_q <= value;
    end
  end

  // Values under the floor only skew the duty cycle, so they act as the floor.
  always_comb begin
    div_eff = (raw_q < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : raw_q;
    stretch = (div_eff != DIV_W'(DIV_MIN));
  end

endmodule

// File: rtl/dcx_upd_timer.sv
module dcx_upd_timer #(
  parameter int BASE_LOG2 = 15,
  parameter int RDIV_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RDIV_W-1:0] rdiv,
  output logic              tick
);

  localparam int CNT_W = BASE_LOG2 + (1 << RDIV_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] last;

  always_comb begin
    span = CNT_W'(1) << (CNT_W'(BASE_LOG2) + CNT_W'(rdiv));
    last = span - CNT_W'(1);
    tick = en && (cnt_q >= last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (cnt_q >= last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dcx_req_arb.sv
module dcx_req_arb #(
  parameter int FRAME_W = 39
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_valid,
  input  logic [FRAME_W-1:0] tx_data,
  output logic               tx_ready,
  input  logic               per_tick,
  input  logic               cont_en,
  input  logic               eng_idle,
  output logic               start,
  output logic [FRAME_W-1:0] start_data
);

  logic               hold_vld_q;
  logic [FRAME_W-1:0] hold_dat_q;
  logic [FRAME_W-1:0] last_dat_q;
  logic               per_pend_q;
  logic               accept;

  always_comb begin
    tx_ready   = !hold_vld_q;
    accept     = tx_valid && tx_ready;
    start      = eng_idle && (hold_vld_q || per_pend_q);
    start_data = hold_vld_q ? hold_dat_q : last_dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      hold_dat_q <= '0;
    end else if (accept) begin
      hold_vld_q <= 1'b1;
      hold_dat_q <= tx_data;
    end else if (start && hold_vld_q) begin
      hold_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_dat_q <= '0;
    end else if (start) begin
      last_dat_q <= start_data;
    end
  end

  // Any frame start satisfies a periodic request; later ticks collapse into one flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_pend_q <= 1'b0;
    end else if (!cont_en) begin
      per_pend_q <= 1'b0;
    end else begin
      per_pend_q <= (per_pend_q && !start) || per_tick;
    end
  end

endmodule

// File: rtl/dcx_shift_eng.sv
module dcx_shift_eng
  import dcx_pkg::*;
#(
  parameter int NUM_DRV   = 3,
  parameter int DGRAM_LEN = 12,
  parameter int DIV_W     = 8,
  parameter int SW_W      = 3,
  localparam int NBITS    = NUM_DRV * (DGRAM_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NBITS-1:0] start_data,
  input  logic [DIV_W-1:0] div_eff,
  input  logic             stretch_en,
  input  logic             miso,
  input  logic [SW_W-1:0]  ref_sw_in,
  output logic             idle,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  output logic             busy,
  output logic             done,
  output logic [NBITS-1:0] rx_data,
  output logic [SW_W-1:0]  ref_sw_stat
);

  localparam int SLOT   = DGRAM_LEN + 1;
  localparam int CNT_W  = DIV_W + 2;
  localparam int BIT_W  = $clog2(NBITS + 1);
  localparam int SLOT_W = $clog2(SLOT + 1);

  eng_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  half_q;
  logic              stretch_q;
  logic              hi_q;
  logic [BIT_W-1:0]  bit_idx_q;
  logic [SLOT_W-1:0] slot_pos_q;
  logic [NBITS-1:0]  shreg_q;
  logic [NBITS-1:0]  rx_sh_q;
  logic [SW_W-1:0]   sw_cap_q;

  logic [CNT_W-1:0]  two_h;
  logic [CNT_W-1:0]  phase_len;
  logic              phase_end;
  logic              last_bit;
  logic              slot_wrap;

  always_comb begin
    two_h = half_q << 1;
    unique case (state_q)
      ENG_LEAD, ENG_TRAIL: phase_len = two_h;
      ENG_BIT:             phase_len = (hi_q && stretch_q && slot_pos_q == '0) ? two_h : half_q;
      default:             phase_len = half_q;
    endcase
    phase_end = (cnt_q == phase_len - CNT_W'(1));
    last_bit  = (bit_idx_q == BIT_W'(NBITS - 1));
    slot_wrap = (slot_pos_q == SLOT_W'(SLOT - 1));
    idle      = (state_q == ENG_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ENG_IDLE;
      cnt_q       <= '0;
      half_q      <= '0;
      stretch_q   <= 1'b0;
      hi_q        <= 1'b0;
      bit_idx_q   <= '0;
      slot_pos_q  <= '0;
      shreg_q     <= '0;
      rx_sh_q     <= '0;
      sw_cap_q    <= '0;
      sclk        <= 1'b1;
      mosi        <= 1'b0;
      cs_n        <= 1'b1;
      busy        <= 1'b0;
      done        <= 1'b0;
      rx_data     <= '0;
      ref_sw_stat <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ENG_IDLE: begin
          if (start) begin
            shreg_q   <= start_data;
            half_q    <= CNT_W'(div_eff) + CNT_W'(1);
            stretch_q <= stretch_en;
            cs_n      <= 1'b0;
            busy      <= 1'b1;
            cnt_q     <= '0;
            state_q   <= ENG_LEAD;
          end
        end
        ENG_LEAD: begin
          if (phase_end) begin
            cnt_q      <= '0;
            hi_q       <= 1'b0;
            bit_idx_q  <= '0;
            slot_pos_q <= '0;
            sclk       <= 1'b0;
            mosi       <= shreg_q[NBITS-1];
            shreg_q    <= {shreg_q[NBITS-2:0], 1'b0};
            state_q    <= ENG_BIT;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ENG_BIT: begin
          if (!phase_end) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (!hi_q) begin
            cnt_q    <= '0;
            hi_q     <= 1'b1;
            sclk     <= 1'b1;
            rx_sh_q  <= {rx_sh_q[NBITS-2:0], miso};
            sw_cap_q <= ref_sw_in;
          end else if (last_bit) begin
            cnt_q   <= '0;
            state_q <= ENG_TRAIL;
          end else begin
            cnt_q      <= '0;
            hi_q       <= 1'b0;
            bit_idx_q  <= bit_idx_q + BIT_W'(1);
            slot_pos_q <= slot_wrap ? '0 : slot_pos_q + SLOT_W'(1);
            sclk       <= 1'b0;
            mosi       <= shreg_q[NBITS-1];
            shreg_q    <= {shreg_q[NBITS-2:0], 1'b0};
          end
        end
        ENG_TRAIL: begin
          if (phase_end) begin
            cs_n        <= 1'b1;
            busy        <= 1'b0;
            done        <= 1'b1;
            mosi        <= 1'b0;
            rx_data     <= rx_sh_q;
            ref_sw_stat <= sw_cap_q;
            state_q     <= ENG_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dcx_chain_tx.sv
module dcx_chain_tx #(
  parameter int NUM_DRV       = 3,
  parameter int DGRAM_LEN     = 12,
  parameter int DIV_W         = 8,
  parameter int DIV_RST       = 15,
  parameter int DIV_MIN       = 7,
  parameter int UPD_BASE_LOG2 = 15,
  parameter int RDIV_W        = 4,
  parameter int SW_W          = 3,
  localparam int FRAME_W      = NUM_DRV * (DGRAM_LEN + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tx_valid,
  output logic                      tx_ready,
  input  logic [FRAME_W-1:0]        tx_data,
  input  logic                      div_load,
  input  logic [DIV_W-1:0]          div_value,
  input  logic                      cont_upd,
  input  logic [NUM_DRV*RDIV_W-1:0] ramp_div,
  output logic                      sclk,
  output logic                      mosi,
  output logic                      cs_n,
  input  logic                      miso,
  input  logic [SW_W-1:0]           ref_sw_in,
  output logic                      busy,
  output logic                      done,
  output logic [SW_W-1:0]           ref_sw_stat,
  output logic [FRAME_W-1:0]        rx_data
);

  logic [DIV_W-1:0]   div_eff;
  logic               stretch;
  logic [NUM_DRV-1:0] tick_vec;
  logic               per_tick;
  logic               eng_idle;
  logic               start;
  logic [FRAME_W-1:0] start_data;

  dcx_div_cfg #(
    .DIV_W  (DIV_W),
    .DIV_RST(DIV_RST),
    .DIV_MIN(DIV_MIN)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (div_load),
    .value  (div_value),
    .div_eff(div_eff),
    .stretch(stretch)
  );

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_tmr
    dcx_upd_timer #(
      .BASE_LOG2(UPD_BASE_LOG2),
      .RDIV_W   (RDIV_W)
    ) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (cont_upd),
      .rdiv (ramp_div[g*RDIV_W +: RDIV_W]),
      .tick (tick_vec[g])
    );
  end

  assign per_tick = |tick_vec;

  dcx_req_arb #(
    .FRAME_W(FRAME_W)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .per_tick  (per_tick),
    .cont_en   (cont_upd),
    .eng_idle  (eng_idle),
    .start     (start),
    .start_data(start_data)
  );

  dcx_shift_eng #(
    .NUM_DRV  (NUM_DRV),
    .DGRAM_LEN(DGRAM_LEN),
    .DIV_W    (DIV_W),
    .SW_W     (SW_W)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_data (start_data),
    .div_eff    (div_eff),
    .stretch_en (stretch),
    .miso       (miso),
    .ref_sw_in  (ref_sw_in),
    .idle       (eng_idle),
    .sclk       (sclk),
    .mosi       (mosi),
    .cs_n       (cs_n),
    .busy       (busy),
    .done       (done),
    .rx_data    (rx_data),
    .ref_sw_stat(ref_sw_stat)
  );

endmodule

// File: rtl/dcx_chain_tx_chk.sv
module dcx_chain_tx_chk #(
  parameter int SW_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic            sclk,
  input logic            mosi,
  input logic            cs_n,
  input logic            busy,
  input logic            done,
  input logic [SW_W-1:0] ref_sw_stat
);

  // R4
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  // R6
  sclk_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(sclk)) |-> $stable(mosi));

  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R12
  stat_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sw_stat != $past(ref_sw_stat)) |-> done);

  // R13
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy && !$past(cs_n)));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind dcx_chain_tx dcx_chain_tx_chk #(
  .SW_W(SW_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .sclk       (sclk),
  .mosi       (mosi),
  .cs_n       (cs_n),
  .busy       (busy),
  .done       (done),
  .ref_sw_stat(ref_sw_stat)
);

// File: tb/tb_dcx_chain_tx.sv
`timescale 1ns/1ps
module tb_dcx_chain_tx;

  localparam int NUM_DRV = 3;
  localparam int DGRAM_LEN = 4;
  localparam int DIV_W = 8;
  localparam int RDIV_W = 3;
  localparam int SW_W = 3;
  localparam int BASE = 6;
  localparam int NBITS = NUM_DRV * (DGRAM_LEN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [NBITS-1:0] tx_data = '0;
  logic div_load = 1'b0;
  logic [DIV_W-1:0] div_value = '0;
  logic cont_upd = 1'b0;
  logic [NUM_DRV*RDIV_W-1:0] ramp_div = '0;
  logic sclk, mosi, cs_n, miso, busy, done;
  logic [SW_W-1:0] ref_sw_in = '0;
  logic [SW_W-1:0] ref_sw_stat;
  logic [NBITS-1:0] rx_data;

  always #2.5 clk = ~clk;
  assign miso = mosi;

  dcx_chain_tx #(
    .NUM_DRV(NUM_DRV), .DGRAM_LEN(DGRAM_LEN), .DIV_W(DIV_W), .DIV_RST(15),
    .DIV_MIN(7), .UPD_BASE_LOG2(BASE), .RDIV_W(RDIV_W), .SW_W(SW_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .div_load(div_load), .div_value(div_value),
    .cont_upd(cont_upd), .ramp_div(ramp_div), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .miso(miso), .ref_sw_in(ref_sw_in), .busy(busy),
    .done(done), .ref_sw_stat(ref_sw_stat), .rx_data(rx_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [NBITS-1:0] last_sent = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Port monitor, sampled on falling clock edges.
  int frames = 0, cs_len = 0, busy_len = 0, bits = 0;
  int lo_run = 0, lo_min = 0, lo_max = 0, gap_run = 0, last_gap = 0;
  logic [NBITS-1:0] cap = '0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;

  always @(negedge clk) begin
    if (prev_cs && !cs_n) begin
      frames++;
      cs_len = 0; busy_len = 0; bits = 0; cap = '0;
      lo_run = 0; lo_min = 1 << 20; lo_max = 0;
      last_gap = gap_run;
    end
    if (cs_n) gap_run++;
    else gap_run = 0;
    if (!cs_n) begin
      cs_len++;
      if (busy) busy_len++;
      if (!sclk) lo_run++;
      else if (!prev_sclk) begin
        if (lo_run < lo_min) lo_min = lo_run;
        if (lo_run > lo_max) lo_max = lo_run;
        lo_run = 0;
      end
      if (sclk && !prev_sclk) begin
        cap = {cap[NBITS-2:0], mosi};
        bits++;
      end
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic load_div(input int dv);
    @(negedge clk);
    div_load = 1'b1;
    div_value = DIV_W'(dv);
    @(negedge clk);
    div_load = 1'b0;
  endtask

  task automatic send(input logic [NBITS-1:0] d);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 4000);
    chk(done == 1'b1, "R13 done reached", n, 0);
  endtask

  function automatic int frame_len(input int h, input bit str);
    return 2 * h * (NBITS + 2) + (str ? NUM_DRV * h : 0);
  endfunction

  task automatic run_frame(input logic [NBITS-1:0] d, input int h, input bit str);
    int len;
    send(d);
    wait_done();
    #1;
    len = frame_len(h, str);
    chk(cs_len == len, "R4 R5 chip-select length", cs_len, len);
    chk(busy_len == len, "R4 busy length", busy_len, len);
    chk(lo_min == h && lo_max == h, "R3 low phase", lo_max, h);
    chk(bits == NBITS, "R6 rising edge count", bits, NBITS);
    chk(cap == d, "R6 mosi MSB first", cap, d);
    chk(rx_data == d, "R7 miso capture", rx_data, d);
    chk(busy == 1'b0 && cs_n == 1'b1, "R13 done with busy low", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R13 done one cycle", done, 0);
    last_sent = d;
  endtask

  function automatic logic [NBITS-1:0] pat(input int k);
    case (k)
      0: return '0;
      1: return '1;
      2: return NBITS'(15'h5555);
      default: return NBITS'(15'h2AAA);
    endcase
  endfunction

  function automatic int dv_of(input int k);
    case (k)
      0: return 0;  1: return 5;  2: return 6;  3: return 7; 4: return 8;
      5: return 9;  6: return 12; 7: return 15; default: return 20;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: actual 1 expected 0");
    n_chk++;
    n_fail++;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int f0, cnt, expn, w, eff;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(cs_n == 1 && sclk == 1 && mosi == 0, "R1 link idle in reset", {cs_n, sclk, mosi}, 3'b110);
    chk(busy == 0 && done == 0 && tx_ready == 1 && ref_sw_stat == 0, "R1 status in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 1 && busy == 0 && tx_ready == 1, "R1 after release", cs_n, 1);

    // R2 default divider: half phase 16 clocks, stretched flag bits
    run_frame(NBITS'(15'h1234), 16, 1'b1);
    chk(lo_max == 16, "R2 default divider", lo_max, 16);

    // R3 R4 R5 R6 R7 sweep of divider and payload
    for (int di = 0; di < 9; di++) begin
      load_div(dv_of(di));
      eff = (dv_of(di) < 7) ? 7 : dv_of(di);
      for (int pi = 0; pi < 4; pi++) begin
        run_frame(pat(pi), eff + 1, eff > 7);
      end
    end

    // R11 payload accepted during a frame
    load_div(7);
    send(NBITS'(15'h0F0F));
    repeat (20) @(negedge clk);
    send(NBITS'(15'h70F1));
    chk(tx_ready == 1'b0, "R11 ready low while held", tx_ready, 0);
    wait_done();
    wait_done();
    #1;
    chk(cap == NBITS'(15'h70F1), "R11 held payload sent next", cap, 15'h70F1);
    chk(last_gap == 1, "R11 one-cycle gap", last_gap, 1);
    last_sent = NBITS'(15'h70F1);

    // R12 switch capture
    ref_sw_in = 3'b101;
    run_frame(NBITS'(15'h3C3C), 8, 1'b0);
    chk(ref_sw_stat == 3'b101, "R12 captured at frame end", ref_sw_stat, 5);
    ref_sw_in = 3'b010;
    repeat (500) @(negedge clk);
    chk(ref_sw_stat == 3'b101, "R12 idle change ignored", ref_sw_stat, 5);
    run_frame(NBITS'(15'h4ABC), 8, 1'b0);
    chk(ref_sw_stat == 3'b010, "R12 next frame capture", ref_sw_stat, 2);

    // R8 on-demand only
    f0 = frames;
    repeat (3000) @(negedge clk);
    #1;
    chk(frames == f0 && cs_n == 1'b1, "R8 no frame without request", frames - f0, 0);

    // R9 periodic schedule, slow timers
    ramp_div = {3'd6, 3'd5, 3'd4};
    @(negedge clk);
    #1;
    f0 = frames;
    cont_upd = 1'b1;
    w = 8692;
    repeat (w) @(negedge clk);
    #1;
    expn = 0;
    for (int t = 1; t < w; t++) begin
      if (t % (1 << (BASE + 4)) == 0 || t % (1 << (BASE + 5)) == 0 || t % (1 << (BASE + 6)) == 0)
        expn++;
    end
    cnt = frames - f0;
    chk(cnt == expn, "R9 periodic frame count", cnt, expn);
    chk(cap == last_sent, "R9 repeats last payload", cap, last_sent);
    cont_upd = 1'b0;
    repeat (700) @(negedge clk);

    // R10 fast timers merge into back-to-back frames
    ramp_div = {3'd2, 3'd1, 3'd0};
    @(negedge clk);
    #1;
    f0 = frames;
    cont_upd = 1'b1;
    w = 3000;
    repeat (w) @(negedge clk);
    #1;
    expn = (w - ((1 << BASE) + 1)) / (frame_len(8, 1'b0) + 1) + 1;
    cnt = frames - f0;
    chk(cnt == expn, "R10 merged periodic count", cnt, expn);
    chk(last_gap == 1, "R10 back-to-back gap", last_gap, 1);
    @(negedge clk);
    cont_upd = 1'b0;
    repeat (700) @(negedge clk);
    #1;
    f0 = frames;
    repeat (2000) @(negedge clk);
    #1;
    chk(frames == f0, "R10 disable drops pending", frames - f0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule